// File: doc/BRIEF.md
# Asynchronous SRAM read controller

This block runs read cycles on an external asynchronous static RAM from a synchronous clock domain. A host presents an address with a valid/ready handshake. The controller latches the address and pulls chip select and output enable low together, with write enable held high. It then waits a fixed number of clock cycles before it samples the data bus.

That wait is the largest of three parameters: the address access delay, the chip-select access delay and the output-enable delay. The sample is taken on the clock edge that ends the wait. At that same edge the chip select and output enable are negated. The captured word goes back to the host with a one-cycle valid pulse.

The RAM's output drivers need time to float after they are disabled. For this reason the controller keeps its ready signal low for a further turnaround count before it accepts the next request. All delays are counts of clock cycles, and each count is at least 1.

Top module: `sram_rd_ctrl`

## Requirements
- R1: After reset, sram_cs_n, sram_oe_n and sram_we_n are high (1), req_ready is high and rd_valid is low.
- R2: sram_we_n is high in every cycle, including throughout each read.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both 1. In the cycle that follows, sram_cs_n and sram_oe_n are both low and sram_addr equals the accepted req_addr.
- R4: sram_addr does not change while sram_cs_n is low.
- R5: sram_cs_n and sram_oe_n stay low for exactly W cycles, where W = max(T_AA, T_ACS, T_OE). sram_dq is sampled on the edge that ends the W-th cycle, and both strobes go high at that edge.
- R6: rd_valid is high for exactly one cycle, the first cycle after the strobes go high. In that cycle rd_data carries the word sampled from sram_dq.
- R7: req_ready is low from the cycle after acceptance until the strobes have been high for T_OZ cycles. It returns high after exactly W + T_OZ busy cycles.
- R8: While req_ready is low, req_valid has no effect: sram_addr keeps the accepted address and no new access begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host read request |
| req_addr | input | AW | Host read address |
| req_ready | output | 1 | Controller can accept a request |
| rd_valid | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | DW | Word read from the RAM |
| sram_addr | output | AW | Address to the RAM |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low (always high here) |
| sram_dq | input | DW | Data bus from the RAM |

## Verification
The hardest case to reach from the ports is capture at the exact edge. A bench that drives constant data onto the bus cannot tell a sample taken one cycle early from a correct one. The bench therefore models the RAM: it drives a poison word until the strobes have been low long enough, and only then drives an address-dependent word.

The second hard case is a request that arrives while the controller is busy. The bench holds req_valid high with a different address through the whole access. It drops req_valid just before the turnaround ends, and then checks that the address did not move and that no second access started.

// File: rtl/sram_rd_ctrl.sv
module sram_rd_ctrl #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int T_AA  = 3,
  parameter int T_ACS = 4,
  parameter int T_OE  = 2,
  parameter int T_OZ  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] sram_addr,
  output logic          sram_cs_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  input  logic [DW-1:0] sram_dq
);

  localparam int W_AC = (T_AA > T_ACS) ? T_AA : T_ACS;
  localparam int W    = (W_AC > T_OE) ? W_AC : T_OE;
  localparam int CMAX = (W > T_OZ) ? W : T_OZ;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] W_C  = CW'(W);
  localparam logic [CW-1:0] OZ_C = CW'(T_OZ);

  typedef enum logic [1:0] {IDLE, ACC, TURN} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          valid_q;

  assign req_ready = (state == IDLE);
  assign sram_cs_n = (state != ACC);
  assign sram_oe_n = (state != ACC);
  assign sram_we_n = 1'b1;
  assign sram_addr = addr_q;
  assign rd_data   = data_q;
  assign rd_valid  = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          addr_q <= req_addr;
          cnt    <= CW'(1);
          state  <= ACC;
        end
        ACC: if (cnt == W_C) begin
          data_q  <= sram_dq;
          valid_q <= 1'b1;
          cnt     <= CW'(1);
          state   <= TURN;
        end else begin
          cnt <= cnt + CW'(1);
        end
        TURN: if (cnt == OZ_C) begin
          state <= IDLE;
        end else begin
          cnt <= cnt + CW'(1);
        end
        default: state <= IDLE;
      endcase
    end
  end

  logic [CW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (!sram_cs_n) low_run <= low_run + CW'(1);
    else low_run <= '0;
  end

  // R2
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_n) sram_we_n);

  // R3
  accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!sram_cs_n && !sram_oe_n && sram_addr == $past(req_addr)));

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

  // R5
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> (low_run < W_C));

  // R5
  release_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_cs_n) |-> ($past(low_run) == W_C - CW'(1)));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R6
  pulse_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (sram_cs_n && $past(!sram_cs_n)));

  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n || rd_valid) |-> !req_ready);

endmodule

// File: tb/sram_rd_ctrl_test.sv
module sram_rd_ctrl_test;
  localparam int AW = 8, DW = 16;
  localparam int T_AA = 3, T_ACS = 4, T_OE = 2, T_OZ = 2;
  localparam int W = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rd_valid, cs_n, oe_n, we_n;
  logic [DW-1:0] rd_data, dq;
  logic [AW-1:0] sram_addr;
  int errors = 0, checks = 0;
  int lowcnt = 0;

  always #2 clk = ~clk;

  sram_rd_ctrl #(.AW(AW), .DW(DW), .T_AA(T_AA), .T_ACS(T_ACS), .T_OE(T_OE), .T_OZ(T_OZ)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_cs_n(cs_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_dq(dq));

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return {a, ~a} ^ 16'h3C5A;
  endfunction

  always_ff @(posedge clk) lowcnt <= (!cs_n && !oe_n) ? lowcnt + 1 : 0;
  assign dq = (!cs_n && !oe_n && lowcnt >= W - 1) ? word_of(sram_addr) : 16'hDEAD;

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    check("R1 cs_n", cs_n == 1, cs_n, 1);
    check("R1 oe_n", oe_n == 1, oe_n, 1);
    check("R1 we_n", we_n == 1, we_n, 1);
    check("R1 ready", req_ready == 1, req_ready, 1);
    check("R1 rd_valid", rd_valid == 0, rd_valid, 0);
  endtask

  task automatic read_once(input logic [AW-1:0] a, input logic [AW-1:0] intruder, input bit poke);
    int cyc, k;
    req_valid = 1; req_addr = a;
    @(posedge clk); #1;
    if (poke) req_addr = intruder; else req_valid = 0;
    check("R3 cs_n low", cs_n == 0 && oe_n == 0, {cs_n, oe_n}, 0);
    check("R3 addr", sram_addr == a, sram_addr, a);
    check("R7 ready low", req_ready == 0, req_ready, 0);
    cyc = 0;
    while (cs_n == 0 && cyc < 100) begin
      check("R2 we_n", we_n == 1, we_n, 1);
      check("R4 addr stable", sram_addr == a, sram_addr, a);
      @(posedge clk); #1; cyc++;
    end
    check("R5 strobe length", cyc == W, cyc, W);
    check("R5 oe_n released", oe_n == 1, oe_n, 1);
    check("R6 rd_valid", rd_valid == 1, rd_valid, 1);
    check("R6 rd_data", rd_data == word_of(a), rd_data, word_of(a));
    k = 0;
    while (req_ready == 0 && k < 100) begin
      if (k == T_OZ - 1 && poke) req_valid = 0;
      @(posedge clk); #1; k++;
      if (k == 1) check("R6 pulse width", rd_valid == 0, rd_valid, 0);
      if (poke) check("R8 no new access", cs_n == 1 && sram_addr == a, sram_addr, a);
    end
    check("R7 turnaround", k == T_OZ, k, T_OZ);
    if (poke) begin
      @(posedge clk); #1;
      check("R8 stays idle", cs_n == 1 && req_ready == 1, cs_n, 1);
    end
  endtask

  initial begin
    #300000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    test_reset();
    #10 rst_n = 1;
    @(negedge clk);
    test_reset();
    read_once(8'h00, 8'h00, 0);
    read_once(8'hA5, 8'h00, 0);
    read_once(8'hFF, 8'h00, 0);
    read_once(8'h3C, 8'h77, 1);
    read_once(8'h12, 8'h00, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule